// File: doc/BRIEF.md
# Integer Execute Unit with Condition Field and Carry

This block is the integer execute stage of a scalar pipeline. It takes the decoded fields of one micro-op at a time and works out two operands. Operand A comes from one of two register read ports and can be bit-inverted. Operand B comes from a third read port or from an immediate. The block then performs an add with a selectable carry-in, a bitwise AND, a bitwise OR, or a multiply that keeps the low word.

The result is registered. It is presented one cycle after issue, together with a one-cycle write strobe for the destination register. Two pieces of architectural state live inside the block: a stored carry flag and a 3-bit condition field. The decoder's record and carry-out flags control whether these are updated. Because the carry-in can come from the stored carry and operand A can be inverted, subtraction and extended-precision arithmetic are built from the add path alone. Opcodes outside the four supported ones are flagged as illegal, and such an issue changes no state.

Top module: `int_exec_unit`

## Requirements
- R1: Operand A is `rd1_data_i` when `rd1_vld_i` is set. Otherwise it is `rd3_data_i` when `rd3_vld_i` is set. Otherwise it is zero.
- R2: Operand B is `imm_i` when `imm_vld_i` is set. Otherwise it is `rd2_data_i` when `rd2_vld_i` is set. Otherwise it is zero.
- R3: When `inv_a_i` is set, operand A is replaced by its DATA_W-bit complement before the operation.
- R4: The carry-in is chosen by `cin_sel_i`: 0 gives 0, 1 gives 1, 2 gives the stored carry as it was before this issue, and 3 gives 0.
- R5: `op_i` selects the operation: 0 is A+B+carry-in, 1 is A AND B, 2 is A OR B, and 3 is the low DATA_W bits of A*B. The truncated result appears on `result_o` in the cycle after a legal issue.
- R6: When `cout_en_i` is set on a legal issue, the stored carry `carry_o` takes bit DATA_W of the untruncated result from the following cycle. That bit comes from the sum for add and from the full double-width product for multiply, and it is 0 for AND and OR.
- R7: When `rc_i` is set on a legal issue, `cr0_o` becomes 3'b001 if the truncated result is zero. It becomes 3'b100 if the result's top bit is set, and 3'b010 otherwise.
- R8: `wr_en_o` is high for exactly the one cycle after a legal issue with `wr_vld_i` set, and is low otherwise.
- R9: Opcodes 4 to 7 are illegal. `illegal_o` pulses for one cycle, and `result_o`, `cr0_o` and `carry_o` keep their values with no write strobe.
- R10: In a cycle without `issue_i`, no state changes, and `wr_en_o` and `illegal_o` are low in the next cycle.
- R11: During reset `result_o`, `cr0_o`, `carry_o`, `wr_en_o` and `illegal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | A micro-op is presented this cycle |
| op_i | input | 3 | Operation code |
| rd1_vld_i | input | 1 | Read port 1 value is valid |
| rd1_data_i | input | DATA_W | Read port 1 value |
| rd2_vld_i | input | 1 | Read port 2 value is valid |
| rd2_data_i | input | DATA_W | Read port 2 value |
| rd3_vld_i | input | 1 | Read port 3 value is valid |
| rd3_data_i | input | DATA_W | Read port 3 value |
| imm_vld_i | input | 1 | Immediate is valid |
| imm_i | input | DATA_W | Immediate value |
| inv_a_i | input | 1 | Complement operand A |
| cin_sel_i | input | 2 | Carry-in source select |
| rc_i | input | 1 | Update the condition field |
| cout_en_i | input | 1 | Update the stored carry |
| wr_vld_i | input | 1 | Destination register write requested |
| result_o | output | DATA_W | Truncated result |
| wr_en_o | output | 1 | Destination write strobe |
| cr0_o | output | 3 | Condition field, one-hot less/greater/equal |
| carry_o | output | 1 | Stored carry flag |
| illegal_o | output | 1 | Illegal opcode pulse |

## Verification
The stored carry and the condition field are the only state that lasts across issues. A wrong value in either shows up on `carry_o` or `cr0_o` in the cycle after the issue that corrupts it. A corrupted carry also spreads into the next add that selects the stored carry, and it is seen one issue later on `result_o`. The bench sweeps every opcode, every carry-in select, the inversion flag and mixes of valid flags over edge-case operands, so a stale carry or a missed update shows up at most two issues after it happens. Illegal and idle cycles are checked by confirming that the state outputs stay frozen.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int OPC_W = 3;

    localparam logic [OPC_W-1:0] OPC_ADD = 3'd0;
    localparam logic [OPC_W-1:0] OPC_AND = 3'd1;
    localparam logic [OPC_W-1:0] OPC_OR  = 3'd2;
    localparam logic [OPC_W-1:0] OPC_MUL = 3'd3;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_CA   = 2'd2,
        CIN_RSVD = 2'd3
    } cin_sel_e;

    localparam logic [2:0] CR_LT = 3'b100;
    localparam logic [2:0] CR_GT = 3'b010;
    localparam logic [2:0] CR_EQ = 3'b001;

endpackage

// File: rtl/int_exec_opsel.sv
module int_exec_opsel #(
    parameter int DATA_W = 64
) (
    input  logic              rd1_vld_i,
    input  logic [DATA_W-1:0] rd1_data_i,
    input  logic              rd2_vld_i,
    input  logic [DATA_W-1:0] rd2_data_i,
    input  logic              rd3_vld_i,
    input  logic [DATA_W-1:0] rd3_data_i,
    input  logic              imm_vld_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              inv_a_i,
    output logic [DATA_W-1:0] opa_o,
    output logic [DATA_W-1:0] opb_o
);

    logic [DATA_W-1:0] raw_a;

    always_comb begin
        if (rd1_vld_i) begin
            raw_a = rd1_data_i;
        end else if (rd3_vld_i) begin
            raw_a = rd3_data_i;
        end else begin
            raw_a = '0;
        end
        opa_o = inv_a_i ? ~raw_a : raw_a;
    end

    always_comb begin
        if (imm_vld_i) begin
            opb_o = imm_i;
        end else if (rd2_vld_i) begin
            opb_o = rd2_data_i;
        end else begin
            opb_o = '0;
        end
    end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [OPC_W-1:0]  op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              legal_o
);

    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = 2 * DATA_W;

    logic [SUM_W-1:0]  sum_full;
    logic [PROD_W-1:0] prod_full;

    always_comb begin
        sum_full  = {1'b0, opa_i} + {1'b0, opb_i} + {{DATA_W{1'b0}}, cin_i};
        prod_full = {{DATA_W{1'b0}}, opa_i} * {{DATA_W{1'b0}}, opb_i};
    end

    always_comb begin
        res_o   = '0;
        cout_o  = 1'b0;
        legal_o = 1'b1;
        unique case (op_i)
            OPC_ADD: begin
                res_o  = sum_full[DATA_W-1:0];
                cout_o = sum_full[DATA_W];
            end
            OPC_AND: res_o = opa_i & opb_i;
            OPC_OR:  res_o = opa_i | opb_i;
            OPC_MUL: begin
                res_o  = prod_full[DATA_W-1:0];
                cout_o = prod_full[DATA_W];
            end
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/int_exec_cr0.sv
module int_exec_cr0
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] res_i,
    output logic [2:0]        cr_o
);

    always_comb begin
        if (res_i == '0) begin
            cr_o = CR_EQ;
        end else if (res_i[DATA_W-1]) begin
            cr_o = CR_LT;
        end else begin
            cr_o = CR_GT;
        end
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [2:0]        op_i,
    input  logic              rd1_vld_i,
    input  logic [DATA_W-1:0] rd1_data_i,
    input  logic              rd2_vld_i,
    input  logic [DATA_W-1:0] rd2_data_i,
    input  logic              rd3_vld_i,
    input  logic [DATA_W-1:0] rd3_data_i,
    input  logic              imm_vld_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              inv_a_i,
    input  logic [1:0]        cin_sel_i,
    input  logic              rc_i,
    input  logic              cout_en_i,
    input  logic              wr_vld_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [2:0]        cr0_o,
    output logic              carry_o,
    output logic              illegal_o
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr_en;
        logic              illegal;
        logic [2:0]        cr0;
        logic              carry;
    } exec_state_t;

    exec_state_t st_d, st_q;

    logic [DATA_W-1:0] opa, opb, alu_res;
    logic              cin, alu_cout, alu_legal;
    logic [2:0]        cr_new;

    int_exec_opsel #(.DATA_W(DATA_W)) opsel_i (
        .rd1_vld_i (rd1_vld_i),
        .rd1_data_i(rd1_data_i),
        .rd2_vld_i (rd2_vld_i),
        .rd2_data_i(rd2_data_i),
        .rd3_vld_i (rd3_vld_i),
        .rd3_data_i(rd3_data_i),
        .imm_vld_i (imm_vld_i),
        .imm_i     (imm_i),
        .inv_a_i   (inv_a_i),
        .opa_o     (opa),
        .opb_o     (opb)
    );

    always_comb begin
        unique case (cin_sel_e'(cin_sel_i))
            CIN_ONE: cin = 1'b1;
            CIN_CA:  cin = st_q.carry;
            default: cin = 1'b0;
        endcase
    end

    int_exec_alu #(.DATA_W(DATA_W)) alu_i (
        .op_i   (op_i),
        .opa_i  (opa),
        .opb_i  (opb),
        .cin_i  (cin),
        .res_o  (alu_res),
        .cout_o (alu_cout),
        .legal_o(alu_legal)
    );

    int_exec_cr0 #(.DATA_W(DATA_W)) cr0_i (
        .res_i(alu_res),
        .cr_o (cr_new)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wr_en   = 1'b0;
        st_d.illegal = 1'b0;
        if (issue_i) begin
            if (!alu_legal) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.result = alu_res;
                st_d.wr_en  = wr_vld_i;
                if (rc_i) begin
                    st_d.cr0 = cr_new;
                end
                if (cout_en_i) begin
                    st_d.carry = alu_cout;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o  = st_q.result;
    assign wr_en_o   = st_q.wr_en;
    assign illegal_o = st_q.illegal;
    assign cr0_o     = st_q.cr0;
    assign carry_o   = st_q.carry;

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [2:0]        op_i,
    input logic              cout_en_i,
    input logic              wr_vld_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [2:0]        cr0_o,
    input logic              carry_o,
    input logic              illegal_o
);

    // R7: condition field never has more than one bit set
    a_r7_cr0_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cr0_o));

    // R8: a write strobe needs a legal issue with a write request one cycle earlier
    a_r8_wr_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(rst_n) && $past(issue_i) && $past(wr_vld_i) && !$past(op_i[2])));

    // R9: an illegal issue leaves all architectural state unchanged
    a_r9_illegal_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($stable(cr0_o) && $stable(carry_o) && $stable(result_o) && !wr_en_o));

    // R10: no issue means no change and no strobes
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(issue_i)) |->
            ($stable(cr0_o) && $stable(carry_o) && $stable(result_o) && !wr_en_o && !illegal_o));

    // R6: logical ops with carry-out enabled clear the stored carry
    a_r6_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_i) && $past(cout_en_i) &&
         ($past(op_i) == 3'd1 || $past(op_i) == 3'd2)) |-> !carry_o);

endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .op_i     (op_i),
    .cout_en_i(cout_en_i),
    .wr_vld_i (wr_vld_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .cr0_o    (cr0_o),
    .carry_o  (carry_o),
    .illegal_o(illegal_o)
);

// File: tb/int_exec_unit_tb_top.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;

    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_i = 1'b0;
    logic [2:0]    op_i = '0;
    logic          rd1_vld_i = 1'b0, rd2_vld_i = 1'b0, rd3_vld_i = 1'b0, imm_vld_i = 1'b0;
    logic [W-1:0]  rd1_data_i = '0, rd2_data_i = '0, rd3_data_i = '0, imm_i = '0;
    logic          inv_a_i = 1'b0;
    logic [1:0]    cin_sel_i = '0;
    logic          rc_i = 1'b0, cout_en_i = 1'b0, wr_vld_i = 1'b0;
    logic [W-1:0]  result_o;
    logic          wr_en_o, carry_o, illegal_o;
    logic [2:0]    cr0_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic [W-1:0] m_result = '0;
    logic [2:0]   m_cr0 = '0;
    logic         m_carry = 1'b0;

    always #2 clk = ~clk;

    int_exec_unit #(.DATA_W(W)) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input string ctx, input logic [2:0] op,
                         input bit v1, input logic [W-1:0] d1,
                         input bit v2, input logic [W-1:0] d2,
                         input bit v3, input logic [W-1:0] d3,
                         input bit vi, input logic [W-1:0] im,
                         input bit inv, input logic [1:0] cs,
                         input bit rc, input bit ce, input bit wv);
        logic [W-1:0]   a, b, r;
        logic [2*W-1:0] full;
        bit cin, legal;
        @(negedge clk);
        chk(wr_en_o == 1'b0 && illegal_o == 1'b0, {ctx, "/R10 idle strobes"},
            {62'b0, wr_en_o, illegal_o}, '0);
        issue_i = 1'b1; op_i = op;
        rd1_vld_i = v1; rd1_data_i = d1; rd2_vld_i = v2; rd2_data_i = d2;
        rd3_vld_i = v3; rd3_data_i = d3; imm_vld_i = vi; imm_i = im;
        inv_a_i = inv; cin_sel_i = cs; rc_i = rc; cout_en_i = ce; wr_vld_i = wv;
        a = v1 ? d1 : (v3 ? d3 : '0);
        if (inv) a = ~a;
        b = vi ? im : (v2 ? d2 : '0);
        cin = (cs == 2'd1) ? 1'b1 : ((cs == 2'd2) ? m_carry : 1'b0);
        legal = (op < 3'd4);
        case (op)
            3'd0: full = {{W{1'b0}}, a} + {{W{1'b0}}, b} + {{(2*W-1){1'b0}}, cin};
            3'd1: full = {{W{1'b0}}, a & b};
            3'd2: full = {{W{1'b0}}, a | b};
            default: full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        endcase
        r = full[W-1:0];
        if (legal) begin
            m_result = r;
            if (rc) m_cr0 = (r == '0) ? 3'b001 : (r[W-1] ? 3'b100 : 3'b010);
            if (ce) m_carry = full[W];
        end
        @(negedge clk);
        issue_i = 1'b0;
        chk(result_o == m_result, {ctx, "/R5 result"}, result_o, m_result);
        chk(carry_o == m_carry, {ctx, "/R6 carry"}, {63'b0, carry_o}, {63'b0, m_carry});
        chk(cr0_o == m_cr0, {ctx, "/R7 cr0"}, {61'b0, cr0_o}, {61'b0, m_cr0});
        chk(wr_en_o == (legal && wv), {ctx, "/R8 wr_en"}, {63'b0, wr_en_o}, {63'b0, legal && wv});
        chk(illegal_o == !legal, {ctx, "/R9 illegal"}, {63'b0, illegal_o}, {63'b0, !legal});
    endtask

    function automatic logic [W-1:0] pat(input int p, input int k);
        logic [W-1:0] base;
        case (p)
            0: base = '0;
            1: base = '1;
            2: base = {1'b1, {(W-1){1'b0}}};
            3: base = 64'h0000_0001_0000_0001;
            4: base = 64'h7FFF_FFFF_FFFF_FFFF;
            default: base = 64'h1234_5678_9ABC_DEF0;
        endcase
        return base ^ (64'(k) * 64'h0101_0000_0000_0001);
    endfunction

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        chk(result_o == '0 && cr0_o == '0 && carry_o == 1'b0 && wr_en_o == 1'b0 && illegal_o == 1'b0,
            "R11 reset state", {result_o[59:0], cr0_o, carry_o}, '0);
        rst_n = 1'b1;

        // R1: port 1 beats port 3; port 3 used alone; neither gives zero (op OR, B = 0)
        issue("R1 p1-over-p3", 3'd2, 1, 64'hAA, 0, 0, 1, 64'h55, 0, 0, 0, 2'd0, 1, 0, 1);
        issue("R1 p3-only",    3'd2, 0, 64'hAA, 0, 0, 1, 64'h55, 0, 0, 0, 2'd0, 1, 0, 1);
        issue("R1 none-zero",  3'd2, 0, 64'hAA, 0, 0, 0, 64'h55, 0, 0, 0, 2'd0, 1, 0, 1);
        // R2: immediate beats port 2
        issue("R2 imm-over-p2", 3'd2, 0, 0, 1, 64'h0F, 0, 0, 1, 64'hF000, 0, 2'd0, 1, 0, 1);
        issue("R2 p2-only",     3'd2, 0, 0, 1, 64'h0F, 0, 0, 0, 64'hF000, 0, 2'd0, 1, 0, 1);
        // R3: invert then add with carry 1 gives B - A
        issue("R3 subtract", 3'd0, 1, 64'd5, 1, 64'd12, 0, 0, 0, 0, 1, 2'd1, 1, 1, 1);
        // R4: stored carry used by CA select, reserved select gives zero
        issue("R4 set carry", 3'd0, 1, '1, 1, 64'd1, 0, 0, 0, 0, 0, 2'd0, 1, 1, 1);
        issue("R4 use CA",    3'd0, 1, 64'd10, 1, 64'd20, 0, 0, 0, 0, 0, 2'd2, 1, 0, 1);
        issue("R4 reserved",  3'd0, 1, 64'd10, 1, 64'd20, 0, 0, 0, 0, 0, 2'd3, 1, 0, 1);

        // Sweep: every opcode, inversion, carry select, flag mixes, operand patterns
        for (int op = 0; op < 8; op++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int cs = 0; cs < 4; cs++) begin
                    for (int p = 0; p < 6; p++) begin
                        int k;
                        logic [6:0] f;
                        k = op * 48 + inv * 24 + cs * 6 + p;
                        f = 7'((k * 37) ^ (k >> 2));
                        issue("sweep", 3'(op),
                              f[0], pat(p, k), f[2], pat((p + 1) % 6, k + 1),
                              f[1], pat((p + 2) % 6, k + 2), f[3], pat((p + 3) % 6, k + 3),
                              inv[0], 2'(cs), f[4], f[5], f[6] | f[0]);
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule